// File: doc/BRIEF.md
# Event Notification Routing Sequencer

This block turns an incoming event trigger into queue traffic and a notification request. A trigger carries a descriptor block, a descriptor index and 32 bits of event data. The sequencer looks up the event-queue descriptor in an internal descriptor table. If the descriptor asks for it, the sequencer appends a generation-tagged entry to a circular event queue through a one-cycle memory write port.

Next it applies masking and two-bit coalescing state. It then asks an external presenter whether a dispatched thread accepts the notification. When no thread accepts it, the sequencer can record the priority in a per-target pending byte. Finally it can escalate: it re-enters its own sequence once, using the escalation descriptor, index and data held in the first descriptor. Software loads and inspects both internal tables through plain host read/write ports.

Top module: `evt_route_seq`

## Requirements
- R1: A trigger whose descriptor has its valid bit clear ends the sequence with no queue write, no presenter request and no change to any table.
- R2: With enqueue enabled, the block writes one entry at address qbase + 4*qindex in the first cycle after the trigger is accepted. The entry holds the generation bit in bit 31 and event data bits 30..0 in bits 30..0.
- R3: The queue depth is 2^(qsize+10) entries. The index advances modulo the depth. When the index wraps to 0, the generation bit toggles and the generation-flipped flag takes the new generation value.
- R4: After every enqueue, the updated index and generation are written back to the descriptor table.
- R5: With the silent bit set, the notification stage (coalescing, presenter, backlog) is skipped and the escalation stage runs directly.
- R6: With format 0 and priority 0xFF, the sequence ends after the enqueue step, with no presenter request and no escalation.
- R7: Unless the notify-always bit is set, the notification PQ pair steps 00→10, 10→11, 11→11 and 01→01. Only 00→10 continues to the presenter, and the pair is written back when it changes. With notify-always set, the pair is left untouched.
- R8: The presenter request is held until acknowledged. An acknowledge with a match ends the sequence, with no backlog and no escalation.
- R9: On no match with backlog enabled and format 0, the target's pending byte is ORed with 1<<(7-priority) for priorities 0..7. Larger priorities set no bit.
- R10: On no match with backlog enabled and format 1, cfg_err pulses for one cycle, the pending byte is unchanged and the sequence ends.
- R11: With escalation enabled, the escalation PQ pair steps as in R7 and must allow the escalation; the unconditional bit bypasses it and leaves the pair untouched. The block then restarts with the escalation block, index and data stored in the descriptor.
- R12: Only one escalation level is followed per incoming trigger; a second escalation request ends the sequence.
- R13: busy is high from the cycle after acceptance until the sequence ends, and a trigger presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears both tables |
| trig_valid | input | 1 | Trigger strobe, taken only while busy is low |
| trig_blk | input | BLK_W | Descriptor block (upper table address bits) |
| trig_idx | input | IDX_W | Descriptor index (lower table address bits) |
| trig_data | input | 32 | Event data |
| busy | output | 1 | Sequence in progress |
| qw_en | output | 1 | Queue entry write strobe |
| qw_addr | output | ADDR_W | Byte address of the queue entry |
| qw_data | output | 32 | Queue entry: generation in bit 31 |
| pr_req | output | 1 | Presenter request, held until pr_ack |
| pr_fmt | output | 1 | Notification format bit |
| pr_tgt | output | TGT_W | Target context number |
| pr_prio | output | 8 | Notification priority |
| pr_ack | input | 1 | Presenter answer strobe |
| pr_match | input | 1 | A thread accepted the notification (valid with pr_ack) |
| cfg_err | output | 1 | One-cycle pulse on format-1 backlog configuration error |
| dh_we | input | 1 | Descriptor table host write |
| dh_addr | input | BLK_W+IDX_W | Descriptor table host address ({block, index}) |
| dh_wdata | input | DESC_W | Descriptor word, laid out as the packed descriptor record (valid at MSB, escalation data at LSB) |
| dh_rdata | output | DESC_W | Descriptor word read at dh_addr |
| ch_we | input | 1 | Context table host write |
| ch_addr | input | TGT_W | Context table host address |
| ch_wdata | input | 8 | Pending byte to write |
| ch_rdata | output | 8 | Pending byte read at ch_addr |

## Verification
The trigger is taken at the clock edge where trig_valid is seen with busy low. A queue write is then due in the very next cycle, and the bench samples qw_en exactly one falling edge after that edge. The descriptor write-back lands at the following edge. The presenter request rises two cycles after acceptance, and the acknowledge returns two cycles later from the bench's presenter model. Escalated entries follow a cycle after the escalation stage. A monitor samples at every falling edge and pops queued expectations for queue writes and presenter requests, so order and count are checked as results appear. Table contents and cfg_err pulses are checked only after busy has fallen.

// File: rtl/evr_pkg.sv
`timescale 1ns/1ps
package evr_pkg;
    parameter int BLK_W  = 1;
    parameter int IDX_W  = 3;
    parameter int TGT_W  = 3;
    parameter int ADDR_W = 24;
    parameter int QSZ_W  = 2;
    parameter int DATA_W = 32;
    parameter int PEND_W = 8;

    localparam int DESC_AW = BLK_W + IDX_W;
    localparam int QIDX_W  = 10 + (1 << QSZ_W) - 1;

    typedef struct packed {
        logic               valid;
        logic               enq;
        logic               silent;
        logic               ntf_always;
        logic               backlog;
        logic               escalate;
        logic               esc_uncond;
        logic               fmt;
        logic               gen;
        logic               gflip;
        logic [1:0]         pq_ntf;
        logic [1:0]         pq_esc;
        logic [7:0]         prio;
        logic [QSZ_W-1:0]   qsize;
        logic [QIDX_W-1:0]  qindex;
        logic [ADDR_W-1:0]  qbase;
        logic [TGT_W-1:0]   tgt;
        logic [BLK_W-1:0]   esc_blk;
        logic [IDX_W-1:0]   esc_idx;
        logic [DATA_W-1:0]  esc_data;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    typedef struct packed {
        logic [BLK_W-1:0]  blk;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } trig_t;

    typedef enum logic [2:0] {
        S_IDLE, S_LOOK, S_EVAL, S_PRES, S_ESC
    } seq_st_e;

    // {notify, next_pq}
    function automatic logic [2:0] pq_step(input logic [1:0] pq);
        case (pq)
            2'b00:   pq_step = 3'b1_10;
            2'b10:   pq_step = 3'b0_11;
            2'b11:   pq_step = 3'b0_11;
            default: pq_step = 3'b0_01;
        endcase
    endfunction

    function automatic logic [PEND_W-1:0] prio_bit(input logic [7:0] p);
        if (p < 8'd8)
            prio_bit = PEND_W'(8'h80 >> p[2:0]);
        else
            prio_bit = '0;
    endfunction
endpackage

// File: rtl/evr_table.sv
`timescale 1ns/1ps
module evr_table #(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [W-1:0]  a_wdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [W-1:0]  b_wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [W-1:0]  ra_rdata,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  rb_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (a_we) begin
            mem[a_addr] <= a_wdata;
        end else if (b_we) begin
            mem[b_addr] <= b_wdata;
        end
    end

    assign ra_rdata = mem[ra_addr];
    assign rb_rdata = mem[rb_addr];
endmodule

// File: rtl/evr_qwriter.sv
`timescale 1ns/1ps
module evr_qwriter
    import evr_pkg::*;
(
    input  desc_t              d_in,
    input  logic [DATA_W-1:0]  data,
    output logic [ADDR_W-1:0]  qw_addr,
    output logic [DATA_W-1:0]  qw_data,
    output desc_t              d_out
);
    logic [QIDX_W-1:0] mask;
    logic [QIDX_W-1:0] nidx;
    logic              wrap;

    always_comb begin
        mask    = QIDX_W'((32'd1 << (32'(d_in.qsize) + 32'd10)) - 32'd1);
        nidx    = (d_in.qindex + QIDX_W'(1)) & mask;
        wrap    = (nidx == '0);
        qw_addr = d_in.qbase + ADDR_W'({d_in.qindex, 2'b00});
        qw_data = {d_in.gen, data[DATA_W-2:0]};
        d_out        = d_in;
        d_out.qindex = nidx;
        d_out.gen    = d_in.gen ^ wrap;
        d_out.gflip  = wrap ? ~d_in.gen : d_in.gflip;
    end
endmodule

// File: rtl/evr_fsm.sv
`timescale 1ns/1ps
module evr_fsm
    import evr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               trig_valid,
    input  logic [BLK_W-1:0]   trig_blk,
    input  logic [IDX_W-1:0]   trig_idx,
    input  logic [DATA_W-1:0]  trig_data,
    output logic               busy,
    output logic [DESC_AW-1:0] desc_addr,
    input  logic [DESC_W-1:0]  desc_rd,
    output logic               desc_we,
    output logic [DESC_W-1:0]  desc_wd,
    output logic               qw_en,
    output logic [ADDR_W-1:0]  qw_addr,
    output logic [DATA_W-1:0]  qw_data,
    output logic               pr_req,
    output logic               pr_fmt,
    output logic [TGT_W-1:0]   pr_tgt,
    output logic [7:0]         pr_prio,
    input  logic               pr_ack,
    input  logic               pr_match,
    output logic [TGT_W-1:0]   ctx_addr,
    input  logic [PEND_W-1:0]  ctx_rd,
    output logic               ctx_we,
    output logic [PEND_W-1:0]  ctx_wd,
    output logic               cfg_err
);
    seq_st_e st, nxt;
    trig_t   cur, cur_n;
    logic    lvl, lvl_n;
    desc_t   wd, wd_n;
    desc_t   rd, rd_enq;
    logic [2:0] pq_n3, pq_e3;
    logic       go;

    assign rd = desc_t'(desc_rd);

    evr_qwriter u_qw (
        .d_in    (rd),
        .data    (cur.data),
        .qw_addr (qw_addr),
        .qw_data (qw_data),
        .d_out   (rd_enq)
    );

    assign pq_n3     = pq_step(wd.pq_ntf);
    assign pq_e3     = pq_step(wd.pq_esc);
    assign desc_addr = {cur.blk, cur.idx};
    assign busy      = (st != S_IDLE);
    assign pr_req    = (st == S_PRES);
    assign pr_fmt    = wd.fmt;
    assign pr_tgt    = wd.tgt;
    assign pr_prio   = wd.prio;
    assign ctx_addr  = wd.tgt;
    assign ctx_wd    = ctx_rd | prio_bit(wd.prio);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            cur <= '0;
            lvl <= 1'b0;
            wd  <= '0;
        end else begin
            st  <= nxt;
            cur <= cur_n;
            lvl <= lvl_n;
            wd  <= wd_n;
        end
    end

    always_comb begin
        nxt     = st;
        cur_n   = cur;
        lvl_n   = lvl;
        wd_n    = wd;
        qw_en   = 1'b0;
        desc_we = 1'b0;
        desc_wd = wd;
        ctx_we  = 1'b0;
        cfg_err = 1'b0;
        go      = 1'b0;
        case (st)
            S_IDLE: begin
                if (trig_valid) begin
                    cur_n = '{blk: trig_blk, idx: trig_idx, data: trig_data};
                    lvl_n = 1'b0;
                    nxt   = S_LOOK;
                end
            end
            S_LOOK: begin
                if (!rd.valid) begin
                    nxt = S_IDLE;
                end else begin
                    wd_n = rd;
                    if (rd.enq) begin
                        qw_en   = 1'b1;
                        wd_n    = rd_enq;
                        desc_we = 1'b1;
                        desc_wd = rd_enq;
                    end
                    nxt = S_EVAL;
                end
            end
            S_EVAL: begin
                if (wd.silent) begin
                    nxt = S_ESC;
                end else if (!wd.fmt && wd.prio == 8'hFF) begin
                    nxt = S_IDLE;
                end else if (wd.ntf_always) begin
                    nxt = S_PRES;
                end else begin
                    wd_n.pq_ntf = pq_n3[1:0];
                    if (pq_n3[1:0] != wd.pq_ntf) begin
                        desc_we = 1'b1;
                        desc_wd = wd_n;
                    end
                    nxt = pq_n3[2] ? S_PRES : S_IDLE;
                end
            end
            S_PRES: begin
                if (pr_ack) begin
                    if (pr_match) begin
                        nxt = S_IDLE;
                    end else if (wd.backlog && wd.fmt) begin
                        cfg_err = 1'b1;
                        nxt     = S_IDLE;
                    end else begin
                        ctx_we = wd.backlog;
                        nxt    = S_ESC;
                    end
                end
            end
            S_ESC: begin
                if (wd.escalate) begin
                    go = 1'b1;
                    if (!wd.esc_uncond) begin
                        wd_n.pq_esc = pq_e3[1:0];
                        go          = pq_e3[2];
                        if (pq_e3[1:0] != wd.pq_esc) begin
                            desc_we = 1'b1;
                            desc_wd = wd_n;
                        end
                    end
                end
                if (go && !lvl) begin
                    cur_n = '{blk: wd.esc_blk, idx: wd.esc_idx, data: wd.esc_data};
                    lvl_n = 1'b1;
                    nxt   = S_LOOK;
                end else begin
                    nxt = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    AST_ONE_ENQ: assert property (@(posedge clk) disable iff (rst)
        qw_en |=> !qw_en); // R2
    AST_PR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pr_req && !pr_ack) |=> (pr_req && $stable(pr_tgt) && $stable(pr_prio))); // R8
    AST_CFG_END: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> (st == S_IDLE)); // R10
    AST_ESC_ONCE: assert property (@(posedge clk) disable iff (rst)
        (st == S_ESC && lvl) |=> (st == S_IDLE)); // R12
    AST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && trig_valid) |=> (st == S_LOOK && !lvl)); // R13
endmodule

// File: rtl/evt_route_seq.sv
`timescale 1ns/1ps
module evt_route_seq
    import evr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               trig_valid,
    input  logic [BLK_W-1:0]   trig_blk,
    input  logic [IDX_W-1:0]   trig_idx,
    input  logic [DATA_W-1:0]  trig_data,
    output logic               busy,
    output logic               qw_en,
    output logic [ADDR_W-1:0]  qw_addr,
    output logic [DATA_W-1:0]  qw_data,
    output logic               pr_req,
    output logic               pr_fmt,
    output logic [TGT_W-1:0]   pr_tgt,
    output logic [7:0]         pr_prio,
    input  logic               pr_ack,
    input  logic               pr_match,
    output logic               cfg_err,
    input  logic               dh_we,
    input  logic [DESC_AW-1:0] dh_addr,
    input  logic [DESC_W-1:0]  dh_wdata,
    output logic [DESC_W-1:0]  dh_rdata,
    input  logic               ch_we,
    input  logic [TGT_W-1:0]   ch_addr,
    input  logic [PEND_W-1:0]  ch_wdata,
    output logic [PEND_W-1:0]  ch_rdata
);
    logic [DESC_AW-1:0] desc_addr;
    logic [DESC_W-1:0]  desc_rd, desc_wd;
    logic               desc_we;
    logic [TGT_W-1:0]   ctx_addr;
    logic [PEND_W-1:0]  ctx_rd, ctx_wd;
    logic               ctx_we;

    evr_table #(.W(DESC_W), .AW(DESC_AW)) u_desc (
        .clk(clk), .rst(rst),
        .a_we(desc_we), .a_addr(desc_addr), .a_wdata(desc_wd),
        .b_we(dh_we), .b_addr(dh_addr), .b_wdata(dh_wdata),
        .ra_addr(desc_addr), .ra_rdata(desc_rd),
        .rb_addr(dh_addr), .rb_rdata(dh_rdata)
    );

    evr_table #(.W(PEND_W), .AW(TGT_W)) u_ctx (
        .clk(clk), .rst(rst),
        .a_we(ctx_we), .a_addr(ctx_addr), .a_wdata(ctx_wd),
        .b_we(ch_we), .b_addr(ch_addr), .b_wdata(ch_wdata),
        .ra_addr(ctx_addr), .ra_rdata(ctx_rd),
        .rb_addr(ch_addr), .rb_rdata(ch_rdata)
    );

    evr_fsm u_fsm (
        .clk(clk), .rst(rst),
        .trig_valid(trig_valid), .trig_blk(trig_blk), .trig_idx(trig_idx),
        .trig_data(trig_data), .busy(busy),
        .desc_addr(desc_addr), .desc_rd(desc_rd),
        .desc_we(desc_we), .desc_wd(desc_wd),
        .qw_en(qw_en), .qw_addr(qw_addr), .qw_data(qw_data),
        .pr_req(pr_req), .pr_fmt(pr_fmt), .pr_tgt(pr_tgt), .pr_prio(pr_prio),
        .pr_ack(pr_ack), .pr_match(pr_match),
        .ctx_addr(ctx_addr), .ctx_rd(ctx_rd), .ctx_we(ctx_we), .ctx_wd(ctx_wd),
        .cfg_err(cfg_err)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!qw_en && !pr_req && !cfg_err)); // R13
endmodule

// File: tb/tb_evt_route_seq.sv
`timescale 1ns/1ps
module tb_evt_route_seq;
    import evr_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst;
    logic               trig_valid;
    logic [BLK_W-1:0]   trig_blk;
    logic [IDX_W-1:0]   trig_idx;
    logic [DATA_W-1:0]  trig_data;
    logic               busy, qw_en, pr_req, pr_fmt, cfg_err;
    logic [ADDR_W-1:0]  qw_addr;
    logic [DATA_W-1:0]  qw_data;
    logic [TGT_W-1:0]   pr_tgt;
    logic [7:0]         pr_prio;
    logic               pr_ack, pr_match;
    logic               dh_we, ch_we;
    logic [DESC_AW-1:0] dh_addr;
    logic [DESC_W-1:0]  dh_wdata, dh_rdata;
    logic [TGT_W-1:0]   ch_addr;
    logic [PEND_W-1:0]  ch_wdata, ch_rdata;

    evt_route_seq dut (
        .clk(clk), .rst(rst), .trig_valid(trig_valid), .trig_blk(trig_blk),
        .trig_idx(trig_idx), .trig_data(trig_data), .busy(busy),
        .qw_en(qw_en), .qw_addr(qw_addr), .qw_data(qw_data),
        .pr_req(pr_req), .pr_fmt(pr_fmt), .pr_tgt(pr_tgt), .pr_prio(pr_prio),
        .pr_ack(pr_ack), .pr_match(pr_match), .cfg_err(cfg_err),
        .dh_we(dh_we), .dh_addr(dh_addr), .dh_wdata(dh_wdata), .dh_rdata(dh_rdata),
        .ch_we(ch_we), .ch_addr(ch_addr), .ch_wdata(ch_wdata), .ch_rdata(ch_rdata)
    );

    typedef struct packed { logic [ADDR_W-1:0] a; logic [DATA_W-1:0] d; } qexp_t;
    typedef struct packed { logic [TGT_W-1:0] t; logic [7:0] p; logic f; } pexp_t;

    localparam logic [ADDR_W-1:0] BASE = 24'h001000;

    qexp_t exp_qw[$];
    pexp_t exp_pr[$];
    int    n_chk = 0, n_fail = 0, cfg_cnt = 0, pr_wait = 0;
    bit    match_next = 1'b0;
    string cur_req = "R13";

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // presenter model and scoreboard monitor
    initial begin
        pr_ack = 1'b0;
        pr_match = 1'b0;
        forever begin
            @(negedge clk);
            if (pr_ack) begin
                pr_ack = 1'b0;
            end else if (pr_req) begin
                pr_wait++;
                if (pr_wait == 1) begin
                    if (exp_pr.size() == 0) begin
                        chk(1'b0, cur_req, {pr_tgt, pr_prio, pr_fmt}, 0, "unexpected presenter request");
                    end else begin
                        pexp_t e;
                        e = exp_pr.pop_front();
                        chk({pr_tgt, pr_prio, pr_fmt} == e, cur_req, {pr_tgt, pr_prio, pr_fmt}, e, "presenter request");
                    end
                end
                if (pr_wait == 2) begin
                    pr_ack   = 1'b1;
                    pr_match = match_next;
                    pr_wait  = 0;
                end
            end
            #1;
            if (qw_en) begin
                if (exp_qw.size() == 0) begin
                    chk(1'b0, cur_req, {qw_addr, qw_data}, 0, "unexpected queue write");
                end else begin
                    qexp_t q;
                    q = exp_qw.pop_front();
                    chk({qw_addr, qw_data} == q, cur_req, {qw_addr, qw_data}, q, "queue write");
                end
            end
            if (cfg_err) cfg_cnt++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R13 watchdog: actual=hung expected=idle");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    function automatic desc_t mk();
        desc_t d;
        d = '0;
        d.valid = 1'b1;
        d.ntf_always = 1'b1;
        d.prio = 8'd3;
        d.tgt = 3'd1;
        d.qbase = BASE;
        return d;
    endfunction

    task automatic put_desc(input int a, input desc_t d);
        @(negedge clk);
        dh_we = 1'b1; dh_addr = DESC_AW'(a); dh_wdata = d;
        @(negedge clk);
        dh_we = 1'b0;
    endtask

    task automatic get_desc(input int a, output desc_t d);
        dh_addr = DESC_AW'(a);
        #1;
        d = desc_t'(dh_rdata);
    endtask

    task automatic put_ctx(input int a, input logic [7:0] v);
        @(negedge clk);
        ch_we = 1'b1; ch_addr = TGT_W'(a); ch_wdata = v;
        @(negedge clk);
        ch_we = 1'b0;
    endtask

    task automatic get_ctx(input int a, output logic [7:0] v);
        ch_addr = TGT_W'(a);
        #1;
        v = ch_rdata;
    endtask

    task automatic push_qw(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        exp_qw.push_back('{a: a, d: d});
    endtask

    task automatic push_pr(input int t, input int p, input bit f);
        exp_pr.push_back('{t: TGT_W'(t), p: 8'(p), f: f});
    endtask

    task automatic fire(input int a, input logic [31:0] d, output bit qfirst);
        @(negedge clk);
        while (busy) @(negedge clk);
        trig_valid = 1'b1;
        trig_blk = BLK_W'(a >> IDX_W);
        trig_idx = IDX_W'(a);
        trig_data = d;
        @(negedge clk);
        trig_valid = 1'b0;
        qfirst = qw_en;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic drain();
        chk(exp_qw.size() == 0, cur_req, exp_qw.size(), 0, "queue writes missing");
        chk(exp_pr.size() == 0, cur_req, exp_pr.size(), 0, "presenter requests missing");
        exp_qw.delete();
        exp_pr.delete();
    endtask

    initial begin
        desc_t d, e;
        logic [7:0] c;
        bit qf;
        int c0;
        rst = 1'b1; trig_valid = 1'b0; trig_blk = '0; trig_idx = '0; trig_data = '0;
        dh_we = 1'b0; dh_addr = '0; dh_wdata = '0; ch_we = 1'b0; ch_addr = '0; ch_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state (R13)
        chk(busy == 1'b0, "R13", busy, 0, "busy after reset");
        chk(!qw_en && !pr_req && !cfg_err, "R13", {qw_en, pr_req, cfg_err}, 0, "outputs after reset");
        get_desc(0, d);
        chk(d.valid == 1'b0, "R1", d.valid, 0, "descriptor cleared by reset");

        // R1: invalid descriptor dropped
        cur_req = "R1";
        d = mk(); d.valid = 1'b0; d.enq = 1'b1;
        put_desc(0, d);
        fire(0, 32'h1111, qf);
        chk(qf == 1'b0, "R1", qf, 0, "no write for invalid");
        get_desc(0, e);
        chk(e == d, "R1", e[63:0], d[63:0], "invalid descriptor unchanged");
        drain();

        // R2/R4: entry format, latency, write-back
        cur_req = "R2";
        d = mk(); d.enq = 1'b1; d.gen = 1'b1; d.qindex = 13'd5;
        put_desc(1, d);
        match_next = 1'b1;
        push_qw(BASE + 24'd20, 32'h8000_ABCD);
        push_pr(1, 3, 0);
        fire(1, 32'h0000_ABCD, qf);
        chk(qf == 1'b1, "R2", qf, 1, "queue write one cycle after accept");
        get_desc(1, e);
        chk(e.qindex == 13'd6, "R4", e.qindex, 6, "index written back");
        chk(e.gen == 1'b1, "R4", e.gen, 1, "generation written back");
        drain();
        d = mk(); d.enq = 1'b1;
        put_desc(2, d);
        push_qw(BASE, 32'h7FFF_0001);
        push_pr(1, 3, 0);
        fire(2, 32'hFFFF_0001, qf);
        drain();

        // R3: wrap and generation
        cur_req = "R3";
        d = mk(); d.enq = 1'b1; d.qindex = 13'd1023;
        put_desc(3, d);
        push_qw(BASE + 24'd4092, 32'h0000_0042); push_pr(1, 3, 0);
        fire(3, 32'h42, qf);
        get_desc(3, e);
        chk(e.qindex == 0 && e.gen == 1 && e.gflip == 1, "R3",
            {e.qindex, e.gen, e.gflip}, {13'd0, 2'b11}, "wrap toggles generation");
        push_qw(BASE, 32'h8000_0043); push_pr(1, 3, 0);
        fire(3, 32'h43, qf);
        get_desc(3, e);
        chk(e.qindex == 1 && e.gen == 1 && e.gflip == 1, "R3",
            {e.qindex, e.gen, e.gflip}, {13'd1, 2'b11}, "index after wrap");
        d.gen = 1'b1; d.gflip = 1'b1; d.qindex = 13'd1023;
        put_desc(3, d);
        push_qw(BASE + 24'd4092, 32'h8000_0044); push_pr(1, 3, 0);
        fire(3, 32'h44, qf);
        get_desc(3, e);
        chk(e.qindex == 0 && e.gen == 0 && e.gflip == 0, "R3",
            {e.qindex, e.gen, e.gflip}, {13'd0, 2'b00}, "flag follows new generation");
        d = mk(); d.enq = 1'b1; d.qsize = 2'd1; d.qindex = 13'd1023;
        put_desc(4, d);
        push_qw(BASE + 24'd4092, 32'h0000_0045); push_pr(1, 3, 0);
        fire(4, 32'h45, qf);
        get_desc(4, e);
        chk(e.qindex == 13'd1024 && e.gen == 0, "R3", {e.qindex, e.gen}, {13'd1024, 1'b0}, "larger depth no wrap");
        drain();

        // R5: silent goes straight to escalation
        cur_req = "R5";
        d = mk(); d.enq = 1'b1; d.tgt = 3'd2; d.prio = 8'd4; d.qbase = 24'h002000;
        put_desc(6, d);
        d = mk(); d.silent = 1'b1; d.escalate = 1'b1; d.esc_uncond = 1'b1;
        d.esc_idx = 3'd6; d.esc_data = 32'h5555;
        put_desc(5, d);
        push_qw(24'h002000, 32'h0000_5555);
        push_pr(2, 4, 0);
        fire(5, 32'h9, qf);
        drain();

        // R6: masked descriptor
        cur_req = "R6";
        d = mk(); d.enq = 1'b1; d.prio = 8'hFF; d.escalate = 1'b1; d.esc_uncond = 1'b1;
        d.esc_idx = 3'd6; d.qbase = 24'h002800;
        put_desc(7, d);
        push_qw(24'h002800, 32'h0000_0077);
        fire(7, 32'h77, qf);
        get_desc(6, e);
        chk(e.qindex == 13'd1, "R6", e.qindex, 1, "no escalation when masked");
        drain();

        // R7: notification coalescing
        cur_req = "R7";
        d = mk(); d.ntf_always = 1'b0; d.pq_ntf = 2'b00;
        put_desc(8, d);
        push_pr(1, 3, 0);
        fire(8, 32'h1, qf);
        get_desc(8, e);
        chk(e.pq_ntf == 2'b10, "R7", e.pq_ntf, 2'b10, "00 steps to 10");
        fire(8, 32'h2, qf);
        get_desc(8, e);
        chk(e.pq_ntf == 2'b11, "R7", e.pq_ntf, 2'b11, "10 steps to 11");
        fire(8, 32'h3, qf);
        get_desc(8, e);
        chk(e.pq_ntf == 2'b11, "R7", e.pq_ntf, 2'b11, "11 holds");
        d.pq_ntf = 2'b01;
        put_desc(9, d);
        fire(9, 32'h4, qf);
        get_desc(9, e);
        chk(e.pq_ntf == 2'b01, "R7", e.pq_ntf, 2'b01, "01 holds");
        d = mk(); d.pq_ntf = 2'b00;
        put_desc(10, d);
        push_pr(1, 3, 0);
        fire(10, 32'h5, qf);
        get_desc(10, e);
        chk(e.pq_ntf == 2'b00, "R7", e.pq_ntf, 2'b00, "notify-always leaves pair");
        drain();

        // R8: match ends sequence
        cur_req = "R8";
        d = mk(); d.backlog = 1'b1; d.escalate = 1'b1; d.esc_uncond = 1'b1; d.esc_idx = 3'd6;
        put_desc(11, d);
        match_next = 1'b1;
        push_pr(1, 3, 0);
        fire(11, 32'h6, qf);
        get_ctx(1, c);
        chk(c == 8'h00, "R8", c, 0, "no backlog on match");
        get_desc(6, e);
        chk(e.qindex == 13'd1, "R8", e.qindex, 1, "no escalation on match");
        drain();

        // R9: backlog
        cur_req = "R9";
        match_next = 1'b0;
        put_ctx(3, 8'h01);
        d = mk(); d.backlog = 1'b1; d.tgt = 3'd3; d.prio = 8'd2;
        put_desc(12, d);
        push_pr(3, 2, 0);
        fire(12, 32'h7, qf);
        get_ctx(3, c);
        chk(c == 8'h21, "R9", c, 8'h21, "priority 2 bit");
        d.prio = 8'd9;
        put_desc(13, d);
        push_pr(3, 9, 0);
        fire(13, 32'h8, qf);
        get_ctx(3, c);
        chk(c == 8'h21, "R9", c, 8'h21, "priority above 7 sets nothing");
        d.prio = 8'd0;
        put_desc(12, d);
        push_pr(3, 0, 0);
        fire(12, 32'h9, qf);
        get_ctx(3, c);
        chk(c == 8'hA1, "R9", c, 8'hA1, "priority 0 bit");
        drain();

        // R10: format 1 with backlog
        cur_req = "R10";
        d = mk(); d.fmt = 1'b1; d.backlog = 1'b1; d.tgt = 3'd4;
        d.escalate = 1'b1; d.esc_uncond = 1'b1; d.esc_idx = 3'd6;
        put_desc(14, d);
        c0 = cfg_cnt;
        push_pr(4, 3, 1);
        fire(14, 32'hA, qf);
        chk(cfg_cnt == c0 + 1, "R10", cfg_cnt - c0, 1, "config error pulses once");
        get_ctx(4, c);
        chk(c == 8'h00, "R10", c, 0, "pending byte untouched");
        get_desc(6, e);
        chk(e.qindex == 13'd1, "R10", e.qindex, 1, "no escalation after error");
        drain();

        // R11: escalation coalescing and re-trigger
        cur_req = "R11";
        d = mk(); d.enq = 1'b1; d.qbase = 24'h003000;
        put_desc(9, d);
        d = mk(); d.escalate = 1'b1; d.esc_blk = 1'b1; d.esc_idx = 3'd1; d.esc_data = 32'h1234;
        put_desc(2, d);
        push_pr(1, 3, 0); push_qw(24'h003000, 32'h1234); push_pr(1, 3, 0);
        fire(2, 32'hB, qf);
        get_desc(2, e);
        chk(e.pq_esc == 2'b10, "R11", e.pq_esc, 2'b10, "escalation pair steps");
        push_pr(1, 3, 0);
        fire(2, 32'hC, qf);
        get_desc(2, e);
        chk(e.pq_esc == 2'b11, "R11", e.pq_esc, 2'b11, "escalation coalesced");
        d.esc_uncond = 1'b1; d.pq_esc = 2'b11;
        put_desc(2, d);
        push_pr(1, 3, 0); push_qw(24'h003004, 32'h1234); push_pr(1, 3, 0);
        fire(2, 32'hD, qf);
        get_desc(2, e);
        chk(e.pq_esc == 2'b11, "R11", e.pq_esc, 2'b11, "unconditional leaves pair");
        drain();

        // R12: one escalation level
        cur_req = "R12";
        d = mk(); d.enq = 1'b1; d.silent = 1'b1; d.escalate = 1'b1; d.esc_uncond = 1'b1;
        d.qbase = 24'h004000; d.esc_idx = 3'd4; d.esc_data = 32'hAA;
        put_desc(3, d);
        d.qbase = 24'h005000; d.esc_idx = 3'd3; d.esc_data = 32'hBB;
        put_desc(4, d);
        push_qw(24'h004000, 32'h11); push_qw(24'h005000, 32'hAA);
        fire(3, 32'h11, qf);
        get_desc(3, e);
        chk(e.qindex == 13'd1, "R12", e.qindex, 1, "first descriptor entered once");
        get_desc(4, e);
        chk(e.qindex == 13'd1, "R12", e.qindex, 1, "escalated descriptor entered once");
        drain();

        // R13: trigger while busy ignored
        cur_req = "R13";
        match_next = 1'b1;
        d = mk(); d.enq = 1'b1; d.qbase = 24'h006000;
        put_desc(5, d);
        d = mk(); d.enq = 1'b1; d.qbase = 24'h007000;
        put_desc(7, d);
        push_qw(24'h006000, 32'h77); push_pr(1, 3, 0);
        @(negedge clk);
        trig_valid = 1'b1; trig_blk = '0; trig_idx = 3'd5; trig_data = 32'h77;
        @(negedge clk);
        chk(busy == 1'b1, "R13", busy, 1, "busy after accept");
        trig_idx = 3'd7; trig_data = 32'h88;
        @(negedge clk);
        trig_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        get_desc(7, e);
        chk(e.qindex == 13'd0, "R13", e.qindex, 0, "trigger during busy ignored");
        drain();

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule